// File: doc/BRIEF.md
# Secured Configuration Access Controller

This block sits between a command port and two pieces of on-chip storage: a word-addressed array that models the configuration cells of a programmable logic fabric, and a separate 64-bit user signature made of eight bytes. Commands can program a configuration word, read a word back for verification, preload the fabric's state register, write or read one signature byte, set a security lock, or bulk-erase the part. One command runs at a time. It is accepted when `cmd_valid` is high and `busy` is low. Every command ends with a single-cycle `done` pulse.

The security lock is one-way. Once set, it refuses configuration readback and preload from the next command on. Refused readback returns zero and raises `denied` together with `done`. The signature becomes read-only but stays readable. Only a bulk erase clears the lock, and it wipes the configuration array at the same time. The erase holds `busy` for a parameterised number of cycles. Reset puts the model into the blank, unlocked state.

Top module: `cfg_guard_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `denied` and `locked` are 0, and `rdata` and `preload_q` are all zeros.
- R2: A command is taken at a clock edge where `cmd_valid` is 1 and `busy` is 0. `busy` then stays high for one cycle, or ERASE_CYCLES cycles for an erase. `done` is high for exactly the one cycle after `busy` falls. Opcode values: 0 no-op, 1 program, 2 verify, 3 preload, 4 signature write, 5 signature read, 6 lock, 7 erase.
- R3: A command presented while `busy` is high is dropped and changes no storage.
- R4: Program (1) writes `cmd_wdata` to the word at `cmd_addr`. While unlocked, verify (2) returns that word on `rdata` in the `done` cycle.
- R5: A verify while locked returns all zeros on `rdata`, and `denied` is high in the `done` cycle only.
- R6: Preload (3) copies `cmd_wdata` to `preload_q` while unlocked. While locked, `preload_q` is unchanged and `denied` pulses with `done`.
- R7: A signature read (5) returns the byte selected by the low three bits of `cmd_addr`, whether locked or not.
- R8: A signature write (4) stores `cmd_wdata` in the selected byte only while unlocked. While locked, the byte is unchanged and `denied` pulses with `done`.
- R9: A verify issued back-to-back right after the `done` of a lock command is already refused.
- R10: `locked` never falls except through erase (7). Erase clears `locked` and every configuration word but leaves the signature and `preload_q` alone.
- R11: Commands other than verify and signature read put zero on `rdata` in their `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | ADDR_W | Configuration word or signature byte address |
| cmd_wdata | input | DATA_W | Write data |
| busy | output | 1 | Command in progress; new commands ignored |
| done | output | 1 | One-cycle completion pulse |
| denied | output | 1 | Completed command was refused by the lock |
| rdata | output | DATA_W | Read result, valid with `done` |
| locked | output | 1 | Security lock state |
| preload_q | output | DATA_W | Preloaded fabric state register |

## Verification
Two events can meet in one cycle. The first is the lock taking hold at the same edge that ends the lock command, while the next verify is already being presented. The bench issues that verify back-to-back, in the very `done` cycle of the lock, and expects `denied` with zero data. The second is a command arriving during a bulk erase. The bench holds a signature write on the port while the erase is busy, then reads the byte back and expects it unchanged. The random phase mixes both situations with ordinary traffic against a reference model.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_PROG    = 3'd1,
    OP_VERIFY  = 3'd2,
    OP_PRELOAD = 3'd3,
    OP_SIG_WR  = 3'd4,
    OP_SIG_RD  = 3'd5,
    OP_LOCK    = 3'd6,
    OP_ERASE   = 3'd7
  } op_e;

  // Operations that the security lock refuses
  function automatic logic op_guarded(op_e op);
    return (op == OP_VERIFY) || (op == OP_PRELOAD) || (op == OP_SIG_WR);
  endfunction

  function automatic logic op_denied(op_e op, logic lock);
    return lock && op_guarded(op);
  endfunction

  // Cycles that busy stays high for a command
  function automatic int unsigned busy_len(op_e op, int unsigned erase_cycles);
    return (op == OP_ERASE) ? erase_cycles : 1;
  endfunction

endpackage

// File: rtl/cfg_guard_seq.sv
module cfg_guard_seq
  import cfg_guard_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int ERASE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              exec_fire,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;
  op_e              op_in;

  assign op_in     = op_e'(cmd_op);
  assign accept    = cmd_valid && !run_q;
  assign busy      = run_q;
  assign exec_fire = run_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      op_q    <= OP_NOP;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      run_q   <= 1'b1;
      cnt_q   <= (op_in == OP_ERASE) ? CNT_W'(ERASE_CYCLES - 1) : '0;
      op_q    <= op_in;
      addr_q  <= cmd_addr;
      wdata_q <= cmd_wdata;
    end else if (exec_fire) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R3
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cmd_valid) |=> ($stable(op_q) && $stable(addr_q) && $stable(wdata_q)));

  // R2
  fire_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_fire |=> !busy);

endmodule

// File: rtl/cfg_guard_store.sv
module cfg_guard_store
  import cfg_guard_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_fire,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_rd,
  output logic              lock_q,
  output logic [DATA_W-1:0] preload_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  assign cfg_rd = mem[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      lock_q    <= 1'b0;
      preload_q <= '0;
    end else if (exec_fire) begin
      case (op)
        OP_PROG:    mem[addr] <= wdata;
        OP_PRELOAD: if (!lock_q) preload_q <= wdata;
        OP_LOCK:    lock_q <= 1'b1;
        OP_ERASE: begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
          lock_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(exec_fire && (op == OP_ERASE)));

  // R10
  erase_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && op == OP_ERASE) |=> (!lock_q && mem[0] == '0));

  // R6
  preload_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && exec_fire && op == OP_PRELOAD) |=> $stable(preload_q));

endmodule

// File: rtl/cfg_guard_sig.sv
module cfg_guard_sig
  import cfg_guard_pkg::*;
#(
  parameter int SIG_BYTES = 8,
  parameter int DATA_W    = 8,
  parameter int SA_W      = $clog2(SIG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_fire,
  input  op_e               op,
  input  logic [SA_W-1:0]   sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lock,
  output logic [DATA_W-1:0] sig_rd
);
  logic [DATA_W-1:0]           sig_b [SIG_BYTES];
  logic [SIG_BYTES*DATA_W-1:0] sig_flat;
  logic                        wr_ok;

  assign wr_ok  = exec_fire && (op == OP_SIG_WR) && !lock;
  assign sig_rd = sig_b[sel];

  for (genvar g = 0; g < SIG_BYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)                         sig_b[g] <= '0;
      else if (wr_ok && sel == SA_W'(g))  sig_b[g] <= wdata;
    end
    assign sig_flat[g*DATA_W +: DATA_W] = sig_b[g];
  end

  // R8
  sig_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && exec_fire && op == OP_SIG_WR) |=> $stable(sig_flat));

endmodule

// File: rtl/cfg_guard_ctrl.sv
module cfg_guard_ctrl
  import cfg_guard_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int DATA_W       = 8,
  parameter int SIG_BYTES    = 8,
  parameter int ERASE_CYCLES = 4,
  parameter int ADDR_W       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic              denied,
  output logic [DATA_W-1:0] rdata,
  output logic              locked,
  output logic [DATA_W-1:0] preload_q
);
  localparam int SA_W = $clog2(SIG_BYTES);

  logic              exec_fire;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] cfg_rd;
  logic [DATA_W-1:0] sig_rd;
  logic [DATA_W-1:0] rd_next;
  logic              deny_now;

  cfg_guard_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYCLES(ERASE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
    .exec_fire(exec_fire), .op_q(op_q), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  cfg_guard_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .exec_fire(exec_fire), .op(op_q),
    .addr(addr_q), .wdata(wdata_q), .cfg_rd(cfg_rd), .lock_q(locked),
    .preload_q(preload_q)
  );

  cfg_guard_sig #(.SIG_BYTES(SIG_BYTES), .DATA_W(DATA_W), .SA_W(SA_W)) u_sig (
    .clk(clk), .rst_n(rst_n), .exec_fire(exec_fire), .op(op_q),
    .sel(addr_q[SA_W-1:0]), .wdata(wdata_q), .lock(locked), .sig_rd(sig_rd)
  );

  assign deny_now = op_denied(op_q, locked);

  always_comb begin
    case (op_q)
      OP_VERIFY: rd_next = locked ? '0 : cfg_rd;
      OP_SIG_RD: rd_next = sig_rd;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      denied <= 1'b0;
      rdata  <= '0;
    end else begin
      done   <= exec_fire;
      denied <= exec_fire && deny_now;
      if (exec_fire) rdata <= rd_next;
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  denied_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    denied |-> done);

  // R5
  denied_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    denied |-> (rdata == '0));

  // R9
  lock_then_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && op_q == OP_VERIFY && $past(locked)) |=> denied);

endmodule

// File: tb/cfg_guard_ctrl_tb_top.sv
module cfg_guard_ctrl_tb_top;
  localparam int DEPTH = 16, DATA_W = 8, SIGB = 8, ERASE_CYCLES = 4, ADDR_W = 4;
  localparam logic [2:0] C_NOP = 3'd0, C_PROG = 3'd1, C_VER = 3'd2, C_PRE = 3'd3,
                         C_SWR = 3'd4, C_SRD = 3'd5, C_LOCK = 3'd6, C_ERASE = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic busy, done, denied, locked;
  logic [DATA_W-1:0] rdata, preload_q;

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [7:0] m_cfg [DEPTH];
  logic [7:0] m_sig [SIGB];
  logic       m_lock;
  logic [7:0] m_pre;

  always #5 clk = ~clk;

  cfg_guard_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .denied(denied), .rdata(rdata), .locked(locked), .preload_q(preload_q)
  );

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_rd(logic [2:0] op, logic [3:0] a);
    if (op == C_VER) return m_lock ? 0 : int'(m_cfg[a]);
    if (op == C_SRD) return int'(m_sig[a[2:0]]);
    return 0;
  endfunction

  function automatic int exp_den(logic [2:0] op);
    return (m_lock && (op == C_VER || op == C_PRE || op == C_SWR)) ? 1 : 0;
  endfunction

  function automatic string tag_of(logic [2:0] op);
    case (op)
      C_PROG:  return "R4";
      C_VER:   return m_lock ? "R5" : "R4";
      C_PRE:   return "R6";
      C_SWR:   return "R8";
      C_SRD:   return "R7";
      C_ERASE: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model_update(logic [2:0] op, logic [3:0] a, logic [7:0] d);
    case (op)
      C_PROG:  m_cfg[a] = d;
      C_PRE:   if (!m_lock) m_pre = d;
      C_SWR:   if (!m_lock) m_sig[a[2:0]] = d;
      C_LOCK:  m_lock = 1'b1;
      C_ERASE: begin
        for (int i = 0; i < DEPTH; i++) m_cfg[i] = 8'h00;
        m_lock = 1'b0;
      end
      default: ;
    endcase
  endtask

  // Called at a negedge; returns at the negedge where done is high
  task automatic run_cmd(logic [2:0] op, logic [3:0] a, logic [7:0] d,
                         output int rd, output int dn, output int bc);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    bc = 0;
    while (done !== 1'b1) begin
      if (busy) bc++;
      @(negedge clk);
    end
    rd = int'(rdata);
    dn = int'(denied);
  endtask

  task automatic do_cmd(logic [2:0] op, logic [3:0] a, logic [7:0] d);
    int rd, dn, bc, erd, eden, ebc;
    string t;
    erd  = exp_rd(op, a);
    eden = exp_den(op);
    ebc  = (op == C_ERASE) ? ERASE_CYCLES : 1;
    t    = tag_of(op);
    run_cmd(op, a, d, rd, dn, bc);
    check(t, "rdata", rd, erd);
    check(t, "denied", dn, eden);
    check("R2", "busy cycles", bc, ebc);
    model_update(op, a, d);
    #1;
    check("R10", "locked", int'(locked), int'(m_lock));
    check("R6", "preload_q", int'(preload_q), int'(m_pre));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int rd, dn, bc;
    void'($urandom(32'h5eed_0c1a));
    for (int i = 0; i < DEPTH; i++) m_cfg[i] = 8'h00;
    for (int i = 0; i < SIGB; i++) m_sig[i] = 8'h00;
    m_lock = 1'b0; m_pre = 8'h00;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "denied", int'(denied), 0);
    check("R1", "locked", int'(locked), 0);
    check("R1", "rdata", int'(rdata), 0);
    check("R1", "preload_q", int'(preload_q), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 program and verify
    for (int i = 0; i < DEPTH; i++) do_cmd(C_PROG, 4'(i), 8'(i * 13 + 7));
    for (int i = 0; i < DEPTH; i++) do_cmd(C_VER, 4'(i), 8'h00);
    // R2 done lasts one cycle
    @(negedge clk);
    check("R2", "done single cycle", int'(done), 0);
    // R7 signature bytes
    for (int i = 0; i < SIGB; i++) do_cmd(C_SWR, 4'(i), 8'(i * 17 + 3));
    for (int i = 0; i < SIGB; i++) do_cmd(C_SRD, 4'(i + 8), 8'h00);
    // R6 preload, R11 no-op
    do_cmd(C_PRE, 4'd0, 8'hC3);
    do_cmd(C_NOP, 4'd0, 8'hFF);

    // R3 command held during erase busy is dropped
    cmd_valid = 1'b1; cmd_op = C_ERASE; cmd_addr = '0; cmd_wdata = '0;
    @(negedge clk);
    check("R3", "busy after erase accept", int'(busy), 1);
    cmd_op = C_SWR; cmd_addr = 4'd0; cmd_wdata = 8'h5A;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    model_update(C_ERASE, 4'd0, 8'h00);
    do_cmd(C_SRD, 4'd0, 8'h00);
    do_cmd(C_VER, 4'd5, 8'h00);

    // R9 lock then verify back-to-back
    do_cmd(C_PROG, 4'd9, 8'hA5);
    do_cmd(C_LOCK, 4'd0, 8'h00);
    run_cmd(C_VER, 4'd9, 8'h00, rd, dn, bc);
    check("R9", "verify after lock denied", dn, 1);
    check("R9", "verify after lock rdata", rd, 0);
    // R6 R8 R7 while locked
    do_cmd(C_PRE, 4'd0, 8'h3C);
    do_cmd(C_SWR, 4'd2, 8'hEE);
    do_cmd(C_SRD, 4'd2, 8'h00);
    do_cmd(C_LOCK, 4'd0, 8'h00);
    do_cmd(C_PROG, 4'd1, 8'h11);
    // R10 erase unlocks and clears
    do_cmd(C_ERASE, 4'd0, 8'h00);
    do_cmd(C_VER, 4'd9, 8'h00);
    do_cmd(C_SRD, 4'd3, 8'h00);

    // Random mix
    for (int n = 0; n < 500; n++) begin
      int r;
      logic [2:0] op;
      r = int'($urandom % 20);
      if (r < 5) op = C_PROG;
      else if (r < 9) op = C_VER;
      else if (r < 11) op = C_PRE;
      else if (r < 14) op = C_SWR;
      else if (r < 17) op = C_SRD;
      else if (r == 17) op = C_LOCK;
      else if (r == 18) op = C_ERASE;
      else op = C_NOP;
      do_cmd(op, 4'($urandom), 8'($urandom));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule